// File: doc/BRIEF.md
# Halfword-Swapping Ethernet DMA Data Path

This block moves data between an Ethernet controller and system memory. A transfer is requested with a device-side byte address, a byte length, a direction and a swap flag. The block turns the request into a stream of memory beats on a valid/ready interface. Each beat is one 16-bit halfword wide. The memory address of every beat is the running device address bitwise-ORed with an upper-address value. That value is captured when the request is accepted.

Some controllers have a 16-bit bus whose byte order is the reverse of memory's. For these, the swap flag makes the block exchange the two bytes of every halfword, both on the way to memory and on the way back. It also clears bit 0 of the start address and of the length. Memory writes in this mode are split into 64-byte chunks, and a burst-end marker closes each chunk. Without the swap flag, data, address and length go through untouched. An odd length then ends with a single-byte beat.

A request is taken only while the block is idle. A one-cycle done pulse follows the acceptance of the final beat. A zero-length request finishes at once and produces no beat.

Top module: `eth_hws_dma`

## Requirements
- R1: Every memory beat's address equals the captured upper-address value ORed with the transfer's current device address.
- R2: With swap enabled, bit 0 of the start address and bit 0 of the length are cleared before the first beat.
- R3: With swap enabled on a write to memory, the memory data is the device halfword with its upper and lower bytes exchanged.
- R4: With swap enabled on a read from memory, the data delivered to the device is the memory halfword with its bytes exchanged.
- R5: With swap disabled, data passes unchanged in both directions and address and length are used as given. A final odd byte is sent with byte enable 2'b01 (bit 0 = low byte lane); full beats use 2'b11.
- R6: With swap enabled on writes, the burst-end marker is set on every 32nd beat of the transfer (each 64 bytes). It is also set on the final beat. In all other modes it is set only on the final beat.
- R7: The device address advances by 2 per accepted beat. A transfer of effective length L issues exactly ceil(L/2) beats.
- R8: A request whose effective length is zero issues no beat and raises done in the cycle after it is accepted.
- R9: Done is high for exactly one cycle, in the cycle after the final beat is accepted.
- R10: A request presented while a transfer is in progress is ignored: the running transfer's beats, addresses and length do not change.
- R11: After reset the block is idle, with busy, memory valid and done all low. No beat is offered while idle.
- R12: While a beat is offered but not accepted, its address and byte enables hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_addr_i | input | ADDR_W | Upper-address value ORed into every memory address |
| req_valid_i | input | 1 | Transfer request strobe, taken only when idle |
| req_addr_i | input | ADDR_W | Device-side start byte address |
| req_len_i | input | LEN_W | Transfer length in bytes |
| req_to_mem_i | input | 1 | 1 = device to memory (write), 0 = memory to device (read) |
| req_swap_i | input | 1 | Enable halfword byte exchange and even forcing |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dev_wvalid_i | input | 1 | Device write data valid |
| dev_wdata_i | input | DATA_W | Device write data |
| dev_wready_o | output | 1 | Device write data consumed this cycle |
| dev_rvalid_o | output | 1 | Read data to device valid this cycle |
| dev_rdata_o | output | DATA_W | Read data to device |
| mem_valid_o | output | 1 | Memory beat offered |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_addr_o | output | ADDR_W | Memory byte address of the beat |
| mem_we_o | output | 1 | Beat is a write |
| mem_be_o | output | DATA_W/8 | Byte enables of the beat |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_burst_end_o | output | 1 | Last beat of a chunk or of the transfer |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the accepting cycle |

## Verification
The assertions assume that memory returns read data in the same cycle it accepts a read beat. They also assume that no zero-length request is issued in the cycle a done pulse is already high. The bench keeps to both. Its memory model computes read data combinationally from the offered address. It also waits one idle cycle after every done pulse before it presents the next request. Stalls on memory ready and on device write valid come from fixed cycle patterns. The hold and ignore properties are therefore exercised without any backpressure rule being broken.

// File: rtl/ehd_pkg.sv
package ehd_pkg;

   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/ehd_req_norm.sv
module ehd_req_norm #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 12
) (
   input  logic              swap_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LEN_W-1:0]  len_o
);

   // swapped halfword traffic must start and end on a halfword boundary
   always_comb begin
      addr_o = addr_i;
      len_o  = len_i;
      if (swap_i) begin
         addr_o[0] = 1'b0;
         len_o[0]  = 1'b0;
      end
   end

endmodule

// File: rtl/ehd_lane_swap.sv
module ehd_lane_swap import ehd_pkg::*; #(
   parameter int DATA_W = 16
) (
   input  logic              en_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);

   localparam int N_HALF = DATA_W / HALF_W;

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      logic [HALF_W-1:0] straight;
      logic [HALF_W-1:0] crossed;
      assign straight = d_i[h*HALF_W +: HALF_W];
      assign crossed  = {straight[BYTE_W-1:0], straight[HALF_W-1:BYTE_W]};
      assign q_o[h*HALF_W +: HALF_W] = en_i ? crossed : straight;
   end

endmodule

// File: rtl/ehd_beat_seq.sv
module ehd_beat_seq import ehd_pkg::*; #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 12,
   parameter int BEAT_BYTES  = 2,
   parameter int CHUNK_BYTES = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [LEN_W-1:0]      len_i,
   input  logic                  to_mem_i,
   input  logic                  swap_i,
   input  logic [ADDR_W-1:0]     hi_i,
   input  logic                  src_valid_i,
   input  logic                  mem_ready_i,
   output logic                  run_o,
   output logic                  we_o,
   output logic                  swap_o,
   output logic                  mem_valid_o,
   output logic [ADDR_W-1:0]     mem_addr_o,
   output logic [BEAT_BYTES-1:0] mem_be_o,
   output logic                  mem_burst_end_o,
   output logic                  fire_o,
   output logic                  done_o
);

   localparam int BEATS_PER_CHUNK       = CHUNK_BYTES / BEAT_BYTES;
   localparam int CH_W                  = $clog2(BEATS_PER_CHUNK);
   localparam logic [LEN_W-1:0] STEP    = LEN_W'(BEAT_BYTES);
   localparam logic [ADDR_W-1:0] ASTEP  = ADDR_W'(BEAT_BYTES);
   localparam logic [CH_W-1:0] CH_LAST  = CH_W'(BEATS_PER_CHUNK - 1);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] hi_q;
   logic [LEN_W-1:0]  rem_q;
   logic [CH_W-1:0]   chunk_q;
   logic              we_q;
   logic              swap_q;
   logic              done_q;

   logic run;
   logic last_beat;
   logic chunk_edge;
   logic fire;

   assign run        = (state_q == SEQ_RUN);
   assign last_beat  = (rem_q <= STEP);
   assign chunk_edge = swap_q && we_q && (chunk_q == CH_LAST);
   assign mem_valid_o = run && (!we_q || src_valid_i);
   assign fire       = mem_valid_o && mem_ready_i;

   assign mem_addr_o      = hi_q | cur_q;
   assign mem_burst_end_o = last_beat || chunk_edge;
   assign run_o  = run;
   assign we_o   = we_q;
   assign swap_o = swap_q;
   assign fire_o = fire;
   assign done_o = done_q;

   // a byte lane is enabled while bytes remain to cover it
   for (genvar b = 0; b < BEAT_BYTES; b++) begin : g_be
      assign mem_be_o[b] = (rem_q > LEN_W'(b));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cur_q   <= '0;
         hi_q    <= '0;
         rem_q   <= '0;
         chunk_q <= '0;
         we_q    <= 1'b0;
         swap_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state_q == SEQ_IDLE) begin
            if (start_i) begin
               cur_q   <= addr_i;
               rem_q   <= len_i;
               hi_q    <= hi_i;
               we_q    <= to_mem_i;
               swap_q  <= swap_i;
               chunk_q <= '0;
               if (len_i == '0) begin
                  done_q <= 1'b1;
               end else begin
                  state_q <= SEQ_RUN;
               end
            end
         end else if (fire) begin
            cur_q   <= cur_q + ASTEP;
            chunk_q <= chunk_edge ? '0 : chunk_q + 1'b1;
            if (last_beat) begin
               rem_q   <= '0;
               state_q <= SEQ_IDLE;
               done_q  <= 1'b1;
            end else begin
               rem_q <= rem_q - STEP;
            end
         end
      end
   end

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mem_valid_o);

   a_r12_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      run && !fire |=> $stable(mem_addr_o) && $stable(mem_be_o));

   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      run && !fire |=> $stable(rem_q) && $stable(hi_q) && $stable(we_q) && $stable(swap_q));

   a_r2_even_span: assert property (@(posedge clk) disable iff (!rst_n)
      run && swap_q |-> !cur_q[0] && !rem_q[0]);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !start_i |=> !done_q);

   a_r7_last_done: assert property (@(posedge clk) disable iff (!rst_n)
      fire && last_beat |=> done_q && !run);

endmodule

// File: rtl/eth_hws_dma.sv
module eth_hws_dma import ehd_pkg::*; #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 12,
   parameter int DATA_W      = 16,
   parameter int CHUNK_BYTES = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      hi_addr_i,
   input  logic                   req_valid_i,
   input  logic [ADDR_W-1:0]      req_addr_i,
   input  logic [LEN_W-1:0]       req_len_i,
   input  logic                   req_to_mem_i,
   input  logic                   req_swap_i,
   output logic                   busy_o,
   output logic                   done_o,
   input  logic                   dev_wvalid_i,
   input  logic [DATA_W-1:0]      dev_wdata_i,
   output logic                   dev_wready_o,
   output logic                   dev_rvalid_o,
   output logic [DATA_W-1:0]      dev_rdata_o,
   output logic                   mem_valid_o,
   input  logic                   mem_ready_i,
   output logic [ADDR_W-1:0]      mem_addr_o,
   output logic                   mem_we_o,
   output logic [DATA_W/8-1:0]    mem_be_o,
   output logic [DATA_W-1:0]      mem_wdata_o,
   output logic                   mem_burst_end_o,
   input  logic [DATA_W-1:0]      mem_rdata_i
);

   localparam int BEAT_BYTES = DATA_W / BYTE_W;

   if (DATA_W < HALF_W || (DATA_W % HALF_W) != 0) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 16");
   end
   if (CHUNK_BYTES < 2 * BEAT_BYTES || (CHUNK_BYTES & (CHUNK_BYTES - 1)) != 0) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a power of two of at least two beats");
   end
   if (LEN_W < 2) begin : g_bad_len_w
      $error("LEN_W must be at least 2");
   end

   logic [ADDR_W-1:0] norm_addr;
   logic [LEN_W-1:0]  norm_len;
   logic              run;
   logic              we_q;
   logic              swap_q;
   logic              fire;

   ehd_req_norm #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) i_norm (
      .swap_i (req_swap_i),
      .addr_i (req_addr_i),
      .len_i  (req_len_i),
      .addr_o (norm_addr),
      .len_o  (norm_len)
   );

   ehd_beat_seq #(
      .ADDR_W      (ADDR_W),
      .LEN_W       (LEN_W),
      .BEAT_BYTES  (BEAT_BYTES),
      .CHUNK_BYTES (CHUNK_BYTES)
   ) i_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (req_valid_i),
      .addr_i          (norm_addr),
      .len_i           (norm_len),
      .to_mem_i        (req_to_mem_i),
      .swap_i          (req_swap_i),
      .hi_i            (hi_addr_i),
      .src_valid_i     (dev_wvalid_i),
      .mem_ready_i     (mem_ready_i),
      .run_o           (run),
      .we_o            (we_q),
      .swap_o          (swap_q),
      .mem_valid_o     (mem_valid_o),
      .mem_addr_o      (mem_addr_o),
      .mem_be_o        (mem_be_o),
      .mem_burst_end_o (mem_burst_end_o),
      .fire_o          (fire),
      .done_o          (done_o)
   );

   ehd_lane_swap #(.DATA_W(DATA_W)) i_wr_lanes (
      .en_i (swap_q),
      .d_i  (dev_wdata_i),
      .q_o  (mem_wdata_o)
   );

   ehd_lane_swap #(.DATA_W(DATA_W)) i_rd_lanes (
      .en_i (swap_q),
      .d_i  (mem_rdata_i),
      .q_o  (dev_rdata_o)
   );

   assign busy_o       = run;
   assign mem_we_o     = we_q;
   assign dev_wready_o = fire && we_q;
   assign dev_rvalid_o = fire && !we_q;

   a_r5_pass_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid_o && mem_we_o && !swap_q |-> mem_wdata_o == dev_wdata_i);

   a_r5_pass_read: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rvalid_o && !swap_q |-> dev_rdata_o == mem_rdata_i);

   a_r3_swap_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid_o && mem_we_o && swap_q |->
         mem_wdata_o[HALF_W-1:0] == {dev_wdata_i[BYTE_W-1:0], dev_wdata_i[HALF_W-1:BYTE_W]});

   a_r4_swap_read: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rvalid_o && swap_q |->
         dev_rdata_o[HALF_W-1:0] == {mem_rdata_i[BYTE_W-1:0], mem_rdata_i[HALF_W-1:BYTE_W]});

endmodule

// File: tb/test_eth_hws_dma.sv
`timescale 1ns/1ps
module test_eth_hws_dma;

   localparam int LEN_W = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] hi_addr_i = '0;
   logic        req_valid_i = 1'b0;
   logic [31:0] req_addr_i = '0;
   logic [LEN_W-1:0] req_len_i = '0;
   logic        req_to_mem_i = 1'b0;
   logic        req_swap_i = 1'b0;
   logic        busy_o, done_o;
   logic        dev_wvalid_i = 1'b0;
   logic [15:0] dev_wdata_i;
   logic        dev_wready_o, dev_rvalid_o;
   logic [15:0] dev_rdata_o;
   logic        mem_valid_o;
   logic        mem_ready_i = 1'b0;
   logic [31:0] mem_addr_o;
   logic        mem_we_o;
   logic [1:0]  mem_be_o;
   logic [15:0] mem_wdata_o;
   logic        mem_burst_end_o;
   logic [15:0] mem_rdata_i;

   always #2 clk = ~clk;

   eth_hws_dma i_eth_hws_dma (
      .clk (clk), .rst_n (rst_n), .hi_addr_i (hi_addr_i),
      .req_valid_i (req_valid_i), .req_addr_i (req_addr_i), .req_len_i (req_len_i),
      .req_to_mem_i (req_to_mem_i), .req_swap_i (req_swap_i),
      .busy_o (busy_o), .done_o (done_o),
      .dev_wvalid_i (dev_wvalid_i), .dev_wdata_i (dev_wdata_i), .dev_wready_o (dev_wready_o),
      .dev_rvalid_o (dev_rvalid_o), .dev_rdata_o (dev_rdata_o),
      .mem_valid_o (mem_valid_o), .mem_ready_i (mem_ready_i), .mem_addr_o (mem_addr_o),
      .mem_we_o (mem_we_o), .mem_be_o (mem_be_o), .mem_wdata_o (mem_wdata_o),
      .mem_burst_end_o (mem_burst_end_o), .mem_rdata_i (mem_rdata_i)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int beat_total = 0;
   int last_fire_cyc = -10;
   int base = 0;
   bit active = 1'b0;
   bit stall = 1'b0;
   logic [31:0] e_a0, e_hi;
   int  e_len, e_n;
   bit  e_we, e_swap;

   function automatic logic [15:0] src_word(int k);
      return {8'(k) + 8'h51, 8'(k) ^ 8'hC6};
   endfunction

   function automatic logic [15:0] xchg(logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

   assign dev_wdata_i = src_word(beat_total - base);
   assign mem_rdata_i = {mem_addr_o[7:0] ^ 8'h5A, mem_addr_o[8:1]};

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_valid_o && mem_ready_i) begin
         beat_total <= beat_total + 1;
         last_fire_cyc <= cyc;
      end
      mem_ready_i  <= stall ? ((cyc % 5) != 3) : 1'b1;
      dev_wvalid_i <= stall ? ((cyc % 7) != 2) : 1'b1;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   // beat monitor
   always @(negedge clk) begin : mon
      int k;
      int remb;
      logic [31:0] ea;
      if (rst_n && mem_valid_o && mem_ready_i) begin
         k = beat_total - base;
         if (!active) begin
            chk("R11 beat while idle", 32'd1, 32'd0);
         end else begin
            chk("R7 beat index in range", 32'(k < e_n), 32'd1);
            ea = e_hi | (e_a0 + 32'(2 * k));
            chk(e_swap ? "R2 address" : "R1 address", mem_addr_o, ea);
            remb = e_len - 2 * k;
            chk("R5 byte enables", 32'(mem_be_o), (remb >= 2) ? 32'd3 : 32'd1);
            chk("R6 burst end", 32'(mem_burst_end_o),
                32'((k == e_n - 1) || (e_swap && e_we && (k % 32) == 31)));
            chk("R7 direction", 32'(mem_we_o), 32'(e_we));
            if (e_we) begin
               chk(e_swap ? "R3 write data" : "R5 write data", 32'(mem_wdata_o),
                   32'(e_swap ? xchg(src_word(k)) : src_word(k)));
               chk("R3 device ready", 32'(dev_wready_o), 32'd1);
            end else begin
               chk(e_swap ? "R4 read data" : "R5 read data", 32'(dev_rdata_o),
                   32'(e_swap ? xchg(mem_rdata_i) : mem_rdata_i));
               chk("R4 read valid", 32'(dev_rvalid_o), 32'd1);
            end
         end
      end
   end

   task automatic run_xfer(logic [31:0] addr, int len, bit we, bit swap,
                           logic [31:0] hi, bit stl, bit inject);
      int t;
      @(negedge clk);
      stall  = stl;
      e_a0   = swap ? (addr & ~32'd1) : addr;
      e_len  = swap ? (len & ~1) : len;
      e_n    = (e_len + 1) / 2;
      e_we   = we;
      e_swap = swap;
      e_hi   = hi;
      base   = beat_total;
      active = 1'b1;
      hi_addr_i    = hi;
      req_addr_i   = addr;
      req_len_i    = LEN_W'(len);
      req_to_mem_i = we;
      req_swap_i   = swap;
      req_valid_i  = 1'b1;
      @(posedge clk);
      #1;
      req_valid_i = 1'b0;
      hi_addr_i   = ~hi;
      if (inject) begin
         repeat (3) @(negedge clk);
         chk("R10 busy during transfer", 32'(busy_o), 32'd1);
         req_addr_i   = addr ^ 32'h0000_0F01;
         req_len_i    = LEN_W'(5);
         req_to_mem_i = ~we;
         req_swap_i   = ~swap;
         req_valid_i  = 1'b1;
         @(negedge clk);
         req_valid_i  = 1'b0;
      end
      @(negedge clk);
      t = 1;
      while (!done_o && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk("R7 beat count", 32'(beat_total - base), 32'(e_n));
      if (e_n == 0) chk("R8 zero length done latency", 32'(t), 32'd1);
      else          chk("R9 done one cycle after last beat", 32'(last_fire_cyc), 32'(cyc - 1));
      active = 1'b0;
      @(negedge clk);
      chk("R9 done single cycle", 32'(done_o), 32'd0);
      chk("R11 idle after done", 32'(busy_o), 32'd0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk("R11 reset busy", 32'(busy_o), 32'd0);
      chk("R11 reset valid", 32'(mem_valid_o), 32'd0);
      chk("R11 reset done", 32'(done_o), 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after reset", 32'(mem_valid_o), 32'd0);
      for (int m = 0; m < 4; m++) begin
         for (int len = 0; len <= 70; len++) begin
            logic [31:0] hi;
            hi = (len % 3 == 0) ? 32'h0000_0000 :
                 (len % 3 == 1) ? 32'hA000_0000 : 32'h0300_4001;
            run_xfer(32'h0000_1230 + 32'(len * 3), len, m[1], m[0], hi,
                     len[0], len == 40);
         end
      end
      summary();
      $finish;
   end

endmodule